// File: doc/BRIEF.md
# Bytecode ALU Execute Unit

This block is the execute stage of a compact 64-bit bytecode machine with eleven general registers, numbered 0 to 10. Each accepted instruction carries an 8-bit opcode, a destination index, a source index and a 32-bit immediate. The unit reads the destination register and the chosen operand, computes the result, and writes it back into its own register file on the same clock edge that accepts the instruction. One cycle later it reports completion together with two fault flags.

The unit covers three groups of instructions: whole-word arithmetic, half-word (32-bit) arithmetic, and byte-order conversion. A faulting instruction writes nothing. Register 10 holds the frame address. It may be read as a source but is never written. A combinational read port lets the surrounding logic or a bench read any register.

Top module: `bcx_alu_exec`

## Requirements
- R1: While reset is held and on the first edge after it, every register reads zero, and `done_o` and both fault flags are low. From the first edge after reset onwards, `in_ready` is high.
- R2: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. `done_o` is high for exactly the cycle after each acceptance and low after any edge with no acceptance.
- R3: Opcode layout. Bits [2:0] of 3'b111 select the 64-bit group and 3'b100 select the 32-bit group. Bit 3 picks the operand: 0 for the immediate, 1 for the source register. Bits [7:4] pick the operation: 0 add, 1 sub, 2 mul, 3 unsigned div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate (immediate form only), 9 unsigned modulo, A xor, B move, C arithmetic right shift, E signed div. The result is written to the destination register.
- R4: In the 64-bit group the immediate is sign-extended, except for move (0xb7), which zero-extends it exactly as 0xb4 does.
- R5: The 32-bit group works on the low 32 bits of both operands and always writes zero into the upper 32 bits of the destination.
- R6: The shift count is the low 6 bits of the operand for 64-bit shifts and the low 5 bits for 32-bit shifts.
- R7: Unsigned divide and modulo give the unsigned quotient and remainder. Signed divide truncates toward zero. The most negative value divided by -1 returns the most negative value.
- R8: Divide, modulo or signed divide by a zero operand (the low 32 bits in the 32-bit group) raises `fault_divzero_o` and leaves the register file unchanged.
- R9: Opcode 0xd4 with immediate 16, 32 or 64 keeps the low 16 bits, keeps the low 32 bits, or leaves the destination unchanged.
- R10: Opcode 0xdc with immediate 16 swaps the two low bytes, with 32 reverses the low four bytes, and with 64 reverses all eight bytes. In the 16 and 32 cases the bytes above the reversed field are cleared.
- R11: The following raise `fault_illegal_o` and write nothing: bits [2:0] outside the two groups; bits [7:4] of 0xF; 0xD in the 64-bit group; negate with bit 3 set; a byte-order immediate other than 16, 32 or 64; a destination index of 10 or above; a source index above 10 in the register form. An illegal fault takes priority over a divide-by-zero fault.
- R12: Register 10 never changes after reset, but it can be read as a source operand.
- R13: `peek_data` shows the register chosen by `peek_idx` within the same cycle, and shows zero for an index above 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| op_code | input | 8 | Instruction opcode |
| rd_idx | input | 4 | Destination register index |
| rs_idx | input | 4 | Source register index |
| imm_val | input | 32 | Immediate operand |
| done_o | output | 1 | Previous cycle's instruction completed |
| fault_illegal_o | output | 1 | Completed instruction was illegal |
| fault_divzero_o | output | 1 | Completed instruction divided by zero |
| peek_idx | input | 4 | Register read-port index |
| peek_data | output | 64 | Register read-port data |

## Verification
The hardest cases to reach from the ports need specific register values, because the immediate is only 32 bits wide. Examples are the most negative 64-bit value divided by -1, and a byte reversal of a value with eight distinct bytes. The bench first builds these values with chains of moves, shifts and ors, checking each step, and then applies the corner instruction. Fault priority is exercised by combining a zero divisor with a register-10 destination. A long pseudo-random run then mixes legal and undefined opcodes, out-of-range indices and edge immediates against the reference model.

// File: rtl/bcx_pkg.sv
`timescale 1ns/1ps
package bcx_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'h0,
        OP_SUB   = 4'h1,
        OP_MUL   = 4'h2,
        OP_UDIV  = 4'h3,
        OP_OR    = 4'h4,
        OP_AND   = 4'h5,
        OP_SHL   = 4'h6,
        OP_SHR   = 4'h7,
        OP_NEG   = 4'h8,
        OP_UMOD  = 4'h9,
        OP_XOR   = 4'hA,
        OP_MOV   = 4'hB,
        OP_SAR   = 4'hC,
        OP_BORD  = 4'hD,
        OP_SDIV  = 4'hE,
        OP_NONE  = 4'hF
    } alu_op_e;

    localparam logic [2:0] GRP_WIDE = 3'b111;
    localparam logic [2:0] GRP_HALF = 3'b100;

    // byte-order field width: 0 -> 16 bits, 1 -> 32 bits, 2 -> 64 bits
    typedef struct packed {
        alu_op_e    op;
        logic       half;
        logic       use_reg;
        logic       swap_mode;
        logic [1:0] bo_width;
        logic       legal;
    } dec_t;

endpackage

// File: rtl/bcx_decode.sv
`timescale 1ns/1ps
module bcx_decode
    import bcx_pkg::*;
#(
    parameter int NREGS = 11,
    parameter int IMMW  = 32,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic [7:0]      opcode,
    input  logic [IDXW-1:0] dst,
    input  logic [IDXW-1:0] src,
    input  logic [IMMW-1:0] imm,
    output dec_t            dec
);

    logic grp_ok;
    logic op_ok;
    logic imm_ok;
    logic dst_ok;
    logic src_ok;
    logic is_bord;

    always_comb begin
        dec          = '0;
        dec.op       = alu_op_e'(opcode[7:4]);
        dec.half     = (opcode[2:0] == GRP_HALF);
        dec.use_reg  = opcode[3];
        dec.bo_width = 2'd2;
        grp_ok       = (opcode[2:0] == GRP_HALF) || (opcode[2:0] == GRP_WIDE);
        is_bord      = (opcode[7:4] == 4'hD);
        imm_ok       = 1'b1;

        unique case (opcode[7:4])
            4'hF:    op_ok = 1'b0;
            4'hD:    op_ok = dec.half;
            4'h8:    op_ok = !opcode[3];
            default: op_ok = 1'b1;
        endcase

        if (is_bord) begin
            dec.use_reg   = 1'b0;
            dec.swap_mode = opcode[3];
            if (imm == IMMW'(16))      dec.bo_width = 2'd0;
            else if (imm == IMMW'(32)) dec.bo_width = 2'd1;
            else if (imm == IMMW'(64)) dec.bo_width = 2'd2;
            else                       imm_ok       = 1'b0;
        end
        if (opcode[7:4] == 4'h8) dec.use_reg = 1'b0;

        dst_ok    = int'(dst) < (NREGS - 1);
        src_ok    = !dec.use_reg || (int'(src) < NREGS);
        dec.legal = grp_ok && op_ok && imm_ok && dst_ok && src_ok;
    end

endmodule

// File: rtl/bcx_compute.sv
`timescale 1ns/1ps
module bcx_compute
    import bcx_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF   = XLEN / 2,
    localparam int NBYTES = XLEN / 8,
    localparam int SHW    = $clog2(XLEN)
) (
    input  alu_op_e         op,
    input  logic            half,
    input  logic            swap_mode,
    input  logic [1:0]      bo_width,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            div_zero
);

    function automatic logic [XLEN-1:0] rev_low(input logic [XLEN-1:0] v, input int nb);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
        end
        return r;
    endfunction

    function automatic logic [XLEN-1:0] keep_low(input logic [XLEN-1:0] v, input int nb);
        logic [XLEN-1:0] r;
        r = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) r[8*i +: 8] = v[8*i +: 8];
        end
        return r;
    endfunction

    logic [XLEN-1:0]        opa;
    logic [XLEN-1:0]        opb;
    logic signed [XLEN-1:0] sa;
    logic signed [XLEN-1:0] sb;
    logic [XLEN-1:0]        mag_a;
    logic [XLEN-1:0]        mag_b;
    logic [XLEN-1:0]        mag_q;
    logic [SHW-1:0]         amt;
    logic [XLEN-1:0]        raw;
    int                     nbytes;

    always_comb begin
        if (half) begin
            opa = {{HALF{1'b0}}, a[HALF-1:0]};
            opb = {{HALF{1'b0}}, b[HALF-1:0]};
            sa  = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
            sb  = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
            amt = {1'b0, b[SHW-2:0]};
        end else begin
            opa = a;
            opb = b;
            sa  = a;
            sb  = b;
            amt = b[SHW-1:0];
        end

        div_zero = ((op == OP_UDIV) || (op == OP_UMOD) || (op == OP_SDIV)) && (opb == '0);

        mag_a = sa[XLEN-1] ? (~sa + 1'b1) : sa;
        mag_b = sb[XLEN-1] ? (~sb + 1'b1) : sb;
        mag_q = (mag_b == '0) ? '0 : (mag_a / mag_b);

        nbytes = 2 << bo_width;

        unique case (op)
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_MUL:  raw = opa * opb;
            OP_UDIV: raw = (opb == '0) ? '0 : (opa / opb);
            OP_UMOD: raw = (opb == '0) ? '0 : (opa % opb);
            OP_OR:   raw = opa | opb;
            OP_AND:  raw = opa & opb;
            OP_XOR:  raw = opa ^ opb;
            OP_SHL:  raw = opa << amt;
            OP_SHR:  raw = opa >> amt;
            OP_SAR:  raw = sa >>> amt;
            OP_NEG:  raw = '0 - opa;
            OP_MOV:  raw = opb;
            OP_SDIV: raw = (sa[XLEN-1] ^ sb[XLEN-1]) ? ('0 - mag_q) : mag_q;
            OP_BORD: raw = swap_mode ? rev_low(a, nbytes) : keep_low(a, nbytes);
            default: raw = '0;
        endcase

        if (half && (op != OP_BORD)) res = {{HALF{1'b0}}, raw[HALF-1:0]};
        else                         res = raw;
    end

endmodule

// File: rtl/bcx_alu_exec.sv
`timescale 1ns/1ps
module bcx_alu_exec
    import bcx_pkg::*;
#(
    parameter int NREGS = 11,
    parameter int XLEN  = 64,
    parameter int IMMW  = 32,
    localparam int IDXW = $clog2(NREGS),
    localparam int HALF = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      op_code,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [IDXW-1:0] rs_idx,
    input  logic [IMMW-1:0] imm_val,
    output logic            done_o,
    output logic            fault_illegal_o,
    output logic            fault_divzero_o,
    input  logic [IDXW-1:0] peek_idx,
    output logic [XLEN-1:0] peek_data
);

    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] rf;
        logic                       ready;
        logic                       done;
        logic                       f_ill;
        logic                       f_dz;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    dec_t            dec;
    logic            fire;
    logic [XLEN-1:0] rd_val;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_dz;

    bcx_decode #(.NREGS(NREGS), .IMMW(IMMW)) u_decode (
        .opcode (op_code),
        .dst    (rd_idx),
        .src    (rs_idx),
        .imm    (imm_val),
        .dec    (dec)
    );

    always_comb begin
        rd_val  = (int'(rd_idx) < NREGS) ? st_q.rf[rd_idx] : '0;
        rs_val  = (int'(rs_idx) < NREGS) ? st_q.rf[rs_idx] : '0;
        imm_ext = (dec.op == OP_MOV) ? {{(XLEN-IMMW){1'b0}}, imm_val}
                                     : {{(XLEN-IMMW){imm_val[IMMW-1]}}, imm_val};
        opnd_b  = dec.use_reg ? rs_val : imm_ext;
    end

    bcx_compute #(.XLEN(XLEN)) u_compute (
        .op        (dec.op),
        .half      (dec.half),
        .swap_mode (dec.swap_mode),
        .bo_width  (dec.bo_width),
        .a         (rd_val),
        .b         (opnd_b),
        .res       (alu_res),
        .div_zero  (alu_dz)
    );

    assign fire = in_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.done  = fire;
        st_d.f_ill = fire && !dec.legal;
        st_d.f_dz  = fire && dec.legal && alu_dz;
        if (fire && dec.legal && !alu_dz) begin
            st_d.rf[rd_idx] = alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready        = st_q.ready;
    assign done_o          = st_q.done;
    assign fault_illegal_o = st_q.f_ill;
    assign fault_divzero_o = st_q.f_dz;
    assign peek_data       = (int'(peek_idx) < NREGS) ? st_q.rf[peek_idx] : '0;

    // R2
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> st_q.done);

    // R2
    idle_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !st_q.done);

    // R8
    fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && (st_q.f_ill || st_q.f_dz)) |-> (st_q.rf == $past(st_q.rf)));

    // R12
    frame_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.rf[NREGS-1]));

    // R11
    dst_frame_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (rd_idx == IDXW'(NREGS-1))) |=> st_q.f_ill);

    // R5
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dec.legal && dec.half && (dec.op != OP_BORD)) |-> (alu_res[XLEN-1:HALF] == '0));

endmodule

// File: tb/bcx_alu_exec_bench.sv
`timescale 1ns/1ps
module bcx_alu_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  op_code = 8'h0;
    logic [3:0]  rd_idx = 4'h0;
    logic [3:0]  rs_idx = 4'h0;
    logic [31:0] imm_val = 32'h0;
    logic        done_o;
    logic        fault_illegal_o;
    logic        fault_divzero_o;
    logic [3:0]  peek_idx = 4'h0;
    logic [63:0] peek_data;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic [63:0] mrf [11];

    always #2 clk = ~clk;

    bcx_alu_exec u_bcx_alu_exec (
        .clk, .rst_n, .in_valid, .in_ready, .op_code, .rd_idx, .rs_idx, .imm_val,
        .done_o, .fault_illegal_o, .fault_divzero_o, .peek_idx, .peek_data
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                                  input logic [31:0] imm, output logic ill, output logic dz,
                                  output logic [63:0] res);
        bit w64, w32, rg;
        int k;
        logic [63:0] x, y, q;
        logic [31:0] x32, y32;
        longint sx, sy;
        int s32x, s32y;
        w64 = (op[2:0] == 3'b111);
        w32 = (op[2:0] == 3'b100);
        k   = int'(op[7:4]);
        rg  = op[3];
        ill = 0;
        if (!(w64 || w32)) ill = 1;
        if (k == 15) ill = 1;
        if (k == 13 && !w32) ill = 1;
        if (k == 8 && rg) ill = 1;
        if (k == 13 && !(imm == 16 || imm == 32 || imm == 64)) ill = 1;
        if (d >= 10) ill = 1;
        if (rg && k != 13 && k != 8 && s > 10) ill = 1;
        x = (d < 11) ? mrf[d] : 64'h0;
        if (rg && k != 13 && k != 8) y = (s < 11) ? mrf[s] : 64'h0;
        else if (k == 11) y = {32'h0, imm};
        else y = {{32{imm[31]}}, imm};
        x32 = x[31:0];
        y32 = y[31:0];
        res = 64'h0;
        if (w64) begin
            sx = x; sy = y;
            case (k)
                0: res = x + y;
                1: res = x - y;
                2: res = x * y;
                3: res = (y == 0) ? 0 : x / y;
                4: res = x | y;
                5: res = x & y;
                6: res = x << y[5:0];
                7: res = x >> y[5:0];
                8: res = -x;
                9: res = (y == 0) ? 0 : x % y;
                10: res = x ^ y;
                11: res = y;
                12: res = sx >>> y[5:0];
                14: begin
                    if (sy == 0) q = 0;
                    else if (sx == 64'sh8000000000000000 && sy == -1) q = sx;
                    else q = sx / sy;
                    res = q;
                end
                default: res = 0;
            endcase
        end else begin
            s32x = x32; s32y = y32;
            case (k)
                0: res = {32'h0, x32 + y32};
                1: res = {32'h0, x32 - y32};
                2: res = {32'h0, x32 * y32};
                3: res = (y32 == 0) ? 0 : {32'h0, x32 / y32};
                4: res = {32'h0, x32 | y32};
                5: res = {32'h0, x32 & y32};
                6: res = {32'h0, x32 << y32[4:0]};
                7: res = {32'h0, x32 >> y32[4:0]};
                8: res = {32'h0, -x32};
                9: res = (y32 == 0) ? 0 : {32'h0, x32 % y32};
                10: res = {32'h0, x32 ^ y32};
                11: res = {32'h0, y32};
                12: res = {32'h0, 32'(s32x >>> y32[4:0])};
                13: begin
                    if (!rg) begin
                        if (imm == 16) res = {48'h0, x[15:0]};
                        else if (imm == 32) res = {32'h0, x[31:0]};
                        else res = x;
                    end else begin
                        if (imm == 16) res = {48'h0, x[7:0], x[15:8]};
                        else if (imm == 32) res = {32'h0, x[7:0], x[15:8], x[23:16], x[31:24]};
                        else res = {x[7:0], x[15:8], x[23:16], x[31:24],
                                    x[39:32], x[47:40], x[55:48], x[63:56]};
                    end
                end
                14: begin
                    if (s32y == 0) res = 0;
                    else if (s32x == 32'sh80000000 && s32y == -1) res = {32'h0, x32};
                    else res = {32'h0, 32'(s32x / s32y)};
                end
                default: res = 0;
            endcase
        end
        dz = !ill && (k == 3 || k == 9 || k == 14) && (w32 ? (y32 == 0) : (y == 0));
    endfunction

    task automatic issue(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                         input logic [31:0] imm, input string req);
        logic ill, dz;
        logic [63:0] res;
        model(op, d, s, imm, ill, dz, res);
        @(negedge clk);
        check("R1", "in_ready", {63'h0, in_ready}, 64'h1);
        in_valid = 1'b1; op_code = op; rd_idx = d; rs_idx = s; imm_val = imm;
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
        peek_idx = (d < 11) ? d : 4'd0;
        if (!ill && !dz) mrf[d] = res;
        #0.5;
        check("R2", "done", {63'h0, done_o}, 64'h1);
        check("R11", "illegal flag", {63'h0, fault_illegal_o}, {63'h0, ill});
        check("R8", "divzero flag", {63'h0, fault_divzero_o}, {63'h0, dz});
        check(req, $sformatf("reg %0d after op %h", peek_idx, op), peek_data, mrf[peek_idx]);
        peek_idx = 4'd10;
        #0.5;
        check("R12", "frame register", peek_data, 64'h0);
    endtask

    task automatic idle_cycle;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R2", "done when idle", {63'h0, done_o}, 64'h0);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #0.1;
            check(req, $sformatf("peek %0d", i), peek_data, (i < 11) ? mrf[i] : 64'h0);
        end
    endtask

    function automatic logic [31:0] pick_imm();
        case ($urandom % 10)
            0: return 32'h0;
            1: return 32'hFFFFFFFF;
            2: return 32'd16;
            3: return 32'd32;
            4: return 32'd64;
            5: return 32'h80000000;
            6: return 32'd63;
            7: return 32'd1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #400000;
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) mrf[i] = 64'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "done in reset", {63'h0, done_o}, 64'h0);
        check("R1", "illegal in reset", {63'h0, fault_illegal_o}, 64'h0);
        check("R1", "divzero in reset", {63'h0, fault_divzero_o}, 64'h0);
        sweep("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "ready after reset", {63'h0, in_ready}, 64'h1);
        check("R1", "done after reset", {63'h0, done_o}, 64'h0);
        idle_cycle();

        // R4 R5: moves and extension
        issue(8'hb4, 4'd1, 4'd0, 32'hFFFFFFFF, "R5");
        issue(8'hb7, 4'd2, 4'd0, 32'h80000000, "R4");
        issue(8'h07, 4'd2, 4'd0, 32'hFFFFFFFF, "R4");
        issue(8'h0f, 4'd2, 4'd1, 32'h0, "R3");
        // R6: shift masking
        issue(8'h67, 4'd1, 4'd0, 32'd32, "R6");
        issue(8'hb4, 4'd7, 4'd0, 32'd1, "R3");
        issue(8'h67, 4'd7, 4'd0, 32'd68, "R6");
        issue(8'h64, 4'd1, 4'd0, 32'd33, "R6");
        issue(8'hb4, 4'd8, 4'h0, 32'h80000000, "R5");
        issue(8'hc4, 4'd8, 4'd0, 32'd36, "R6");
        // build 0x0102030405060708 for byte-order tests
        issue(8'hb4, 4'd3, 4'd0, 32'h01020304, "R3");
        issue(8'h67, 4'd3, 4'd0, 32'd32, "R6");
        issue(8'h47, 4'd3, 4'd0, 32'h05060708, "R3");
        issue(8'hbf, 4'd4, 4'd3, 32'h0, "R3");
        issue(8'hdc, 4'd4, 4'd0, 32'd64, "R10");
        issue(8'hbf, 4'd4, 4'd3, 32'h0, "R3");
        issue(8'hdc, 4'd4, 4'd0, 32'd32, "R10");
        issue(8'hbf, 4'd4, 4'd3, 32'h0, "R3");
        issue(8'hdc, 4'd4, 4'd0, 32'd16, "R10");
        issue(8'hbf, 4'd4, 4'd3, 32'h0, "R3");
        issue(8'hd4, 4'd4, 4'd0, 32'd64, "R9");
        issue(8'hd4, 4'd4, 4'd0, 32'd32, "R9");
        issue(8'hd4, 4'd4, 4'd0, 32'd16, "R9");
        issue(8'hdc, 4'd3, 4'd0, 32'd8, "R11");
        issue(8'hdf, 4'd3, 4'd0, 32'd64, "R11");
        // R7: signed division corners
        issue(8'hb4, 4'd4, 4'd0, 32'd1, "R3");
        issue(8'h67, 4'd4, 4'd0, 32'd63, "R6");
        issue(8'hb4, 4'd5, 4'd0, 32'd0, "R3");
        issue(8'h17, 4'd5, 4'd0, 32'd1, "R4");
        issue(8'hef, 4'd4, 4'd5, 32'h0, "R7");
        issue(8'hb4, 4'd6, 4'd0, 32'h80000000, "R3");
        issue(8'hec, 4'd6, 4'd5, 32'h0, "R7");
        issue(8'hb4, 4'd6, 4'd0, 32'd0, "R3");
        issue(8'h17, 4'd6, 4'd0, 32'd7, "R4");
        issue(8'he7, 4'd6, 4'd0, 32'd2, "R7");
        issue(8'h37, 4'd5, 4'd0, 32'd3, "R7");
        issue(8'h97, 4'd3, 4'd0, 32'd1000, "R7");
        // R8: divide by zero
        issue(8'h37, 4'd3, 4'd0, 32'd0, "R8");
        issue(8'h9f, 4'd3, 4'd0, 32'd0, "R8");
        issue(8'h3c, 4'd3, 4'd1, 32'd0, "R8");
        issue(8'he4, 4'd3, 4'd0, 32'd0, "R8");
        // R11 R12: illegal forms and frame register
        issue(8'h07, 4'd10, 4'd0, 32'd1, "R12");
        issue(8'h37, 4'd10, 4'd0, 32'd0, "R11");
        issue(8'h0f, 4'd1, 4'd12, 32'd0, "R11");
        issue(8'h07, 4'd13, 4'd0, 32'd1, "R11");
        issue(8'hf7, 4'd1, 4'd0, 32'd1, "R11");
        issue(8'h8f, 4'd1, 4'd2, 32'd0, "R11");
        issue(8'h06, 4'd1, 4'd0, 32'd1, "R11");
        issue(8'h87, 4'd2, 4'd0, 32'd0, "R3");
        issue(8'h84, 4'd2, 4'd0, 32'd0, "R5");
        issue(8'h0f, 4'd1, 4'd10, 32'd0, "R12");
        idle_cycle();
        sweep("R13");

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] op;
            logic [3:0] d, s;
            op = {4'($urandom), 1'($urandom), ($urandom % 8 == 0) ? 3'($urandom) : (($urandom % 2 == 0) ? 3'b111 : 3'b100)};
            d = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % 10);
            s = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % 11);
            issue(op, d, s, pick_imm(), "R3");
            if (n % 100 == 0) idle_cycle();
        end
        sweep("R13");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule